// File: doc/BRIEF.md
# Serial Control Word Write Port

This block receives 16-bit control words over a three-wire write-only serial link (control clock, control data, latch) and turns them into the configuration fields an audio converter needs. Bits are shifted in MSB first, one per rising edge of the control clock. A rising edge on the latch commits whatever sits in the shift register. There is no chip select, so the latch edge alone marks the end of a word. The control clock may run freely or be gated between words.

The three link inputs come from outside the system clock domain. They are synchronized and their edges are detected on the system clock. The two most significant bits of each word select a register, and the remaining 14 bits carry its payload. One register holds the configuration fields and one holds each channel's volume. The fourth address is reserved and has no effect. An asynchronous active-low reset returns every field to its default.

Top module: `ctlword_port`

## Requirements
- R1: While `rst_n` is low and after its release, outputs hold defaults: `serialMode`=0, `wordLen`=2'b11 (24 bits), `interpSel`=0, `muteEn`=0, `deempCurve`=0, `softReset`=0, and `volLeft`/`volRight` all ones.
- R2: Words are 16 bits, MSB first. Bits [15:14] are the address (0 config, 1 left volume, 2 right volume, 3 reserved) and bits [13:0] are the payload.
- R3: Data is taken only on a rising edge of `ctlClk`. Falling edges and idle gaps of the clock, with data changing meanwhile, leave the shift register untouched.
- R4: No output changes until a rising edge of `ctlLatch`. Each latch edge commits exactly once, and outputs then stay stable until the next latch edge.
- R5: The config payload maps as follows: [1:0] `serialMode` (00 I2S-style, 01 right-justified, 10 DSP, 11 left-justified), [3:2] `wordLen` (00 16, 01 18, 10 20, 11 24 bits), [5:4] `interpSel` (00 8x, 01 4x, 10 2x, 11 stored as is), [6] `muteEn`, [8:7] `deempCurve` (00 44.1 kHz, 01 32 kHz, 10 48 kHz, 11 stored as is) and [9] `softReset`. Bits [13:10] are ignored.
- R6: A word to address 1 loads `volLeft` from payload [9:0]. A word to address 2 loads `volRight` from payload [9:0]. Neither touches the other registers.
- R7: A word to address 3 changes no output.
- R8: A latch after fewer than 16 bits commits the current shift register contents. The register is not cleared by a commit, so the earlier bits form the word's upper part.
- R9: When a control clock rise and a latch rise are detected in the same system cycle, the bit from that clock edge is shifted in first and is part of the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctlClk | input | 1 | Serial control clock, may be gated |
| ctlData | input | 1 | Serial control data, MSB first |
| ctlLatch | input | 1 | Commit strobe, rising-edge active |
| serialMode | output | 2 | Audio serial port format |
| wordLen | output | 2 | Audio word length code |
| interpSel | output | 2 | Interpolation factor code |
| muteEn | output | 1 | Mute request |
| deempCurve | output | 2 | De-emphasis curve select |
| softReset | output | 1 | Software reset request |
| volLeft | output | 10 | Left channel volume |
| volRight | output | 10 | Right channel volume |

## Verification
Shifting a bit and committing a word can fall in the same system cycle. The bench provokes this by raising the control clock and the latch in the same driving step, so that both pass through the equal-depth synchronizers together. It then checks that the committed register reflects a word that includes that final bit, per R9, and not the word from one bit earlier. The expected word comes from a bench-side shift model. Around that case, sweeps over config payloads, volume values, partial words and reserved-address writes compare all outputs with arithmetic models after every latch.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CFG   = 2'd0,
    ADDR_VOL_L = 2'd1,
    ADDR_VOL_R = 2'd2,
    ADDR_RSVD  = 2'd3
  } ctl_addr_e;

  // config payload field positions
  localparam int CFG_MODE_LSB  = 0;
  localparam int CFG_WLEN_LSB  = 2;
  localparam int CFG_INTP_LSB  = 4;
  localparam int CFG_MUTE_BIT  = 6;
  localparam int CFG_DEEMP_LSB = 7;
  localparam int CFG_SRST_BIT  = 9;
  localparam int CFG_USED_W    = 10;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
  } ctl_strobe_t;

endpackage

// File: rtl/ctlword_sync.sv
module ctlword_sync
  import ctlword_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctlClk,
  input  logic        ctlData,
  input  logic        ctlLatch,
  output ctl_strobe_t strobe
);

  localparam int NSIG    = 3;
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_LAT = 2;

  logic [NSIG-1:0]        rawIn;
  logic [NSIG-1:0]        syncOut;
  logic [SYNC_STAGES-1:0] pipe [NSIG];
  logic                   prevClk;
  logic                   prevLat;

  assign rawIn = {ctlLatch, ctlData, ctlClk};

  // the same stage depth on every input keeps data aligned to its clock edge
  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '0;
      else        pipe[g] <= (pipe[g] << 1) | SYNC_STAGES'(rawIn[g]);
    end
    assign syncOut[g] = pipe[g][SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevClk <= 1'b0;
      prevLat <= 1'b0;
    end else begin
      prevClk <= syncOut[IDX_CLK];
      prevLat <= syncOut[IDX_LAT];
    end
  end

  always_comb begin
    strobe.shiftEn  = syncOut[IDX_CLK] & ~prevClk;
    strobe.shiftBit = syncOut[IDX_DAT];
    strobe.commit   = syncOut[IDX_LAT] & ~prevLat;
  end

  // R4
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> !strobe.commit);

  // R3
  single_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.shiftEn |=> !strobe.shiftEn);

endmodule

// File: rtl/ctlword_regs.sv
module ctlword_regs
  import ctlword_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int VOL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_strobe_t       strobe,
  output logic [1:0]        serialMode,
  output logic [1:0]        wordLen,
  output logic [1:0]        interpSel,
  output logic              muteEn,
  output logic [1:0]        deempCurve,
  output logic              softReset,
  output logic [VOL_W-1:0]  volLeft,
  output logic [VOL_W-1:0]  volRight
);

  localparam int PAY_W = WORD_W - ADDR_W;

  logic [WORD_W-1:0]     shiftReg;
  logic [WORD_W-1:0]     nextShift;
  ctl_addr_e             wordAddr;
  logic [CFG_USED_W-1:0] cfgBits;
  logic [VOL_W-1:0]      volBits;

  // a coincident shift is folded in before the commit decodes the word
  always_comb begin
    nextShift = strobe.shiftEn ? {shiftReg[WORD_W-2:0], strobe.shiftBit} : shiftReg;
    wordAddr  = ctl_addr_e'(nextShift[WORD_W-1 -: ADDR_W]);
    cfgBits   = nextShift[CFG_USED_W-1:0];
    volBits   = nextShift[VOL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shiftReg <= '0;
    else        shiftReg <= nextShift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serialMode <= 2'b00;
      wordLen    <= 2'b11;
      interpSel  <= 2'b00;
      muteEn     <= 1'b0;
      deempCurve <= 2'b00;
      softReset  <= 1'b0;
      volLeft    <= '1;
      volRight   <= '1;
    end else if (strobe.commit) begin
      unique case (wordAddr)
        ADDR_CFG: begin
          serialMode <= cfgBits[CFG_MODE_LSB +: 2];
          wordLen    <= cfgBits[CFG_WLEN_LSB +: 2];
          interpSel  <= cfgBits[CFG_INTP_LSB +: 2];
          muteEn     <= cfgBits[CFG_MUTE_BIT];
          deempCurve <= cfgBits[CFG_DEEMP_LSB +: 2];
          softReset  <= cfgBits[CFG_SRST_BIT];
        end
        ADDR_VOL_L: volLeft  <= volBits;
        ADDR_VOL_R: volRight <= volBits;
        ADDR_RSVD:  ;
      endcase
    end
  end

  initial begin
    assert (PAY_W >= CFG_USED_W && PAY_W >= VOL_W);
  end

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> $stable({serialMode, wordLen, interpSel, muteEn, deempCurve, softReset}));

  // R4
  vol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> $stable({volLeft, volRight}));

  // R3
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.shiftEn |=> $stable(shiftReg));

  // R2
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.shiftEn |=> shiftReg[0] == $past(strobe.shiftBit));

  // R7
  rsvd_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && wordAddr == ADDR_RSVD) |=>
      $stable({serialMode, wordLen, interpSel, muteEn, deempCurve, softReset, volLeft, volRight}));

  // R6
  volL_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && wordAddr == ADDR_VOL_L) |=> $stable(volRight));

endmodule

// File: rtl/ctlword_port.sv
module ctlword_port
  import ctlword_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int VOL_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctlClk,
  input  logic             ctlData,
  input  logic             ctlLatch,
  output logic [1:0]       serialMode,
  output logic [1:0]       wordLen,
  output logic [1:0]       interpSel,
  output logic             muteEn,
  output logic [1:0]       deempCurve,
  output logic             softReset,
  output logic [VOL_W-1:0] volLeft,
  output logic [VOL_W-1:0] volRight
);

  ctl_strobe_t strobe;

  ctlword_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctlClk   (ctlClk),
    .ctlData  (ctlData),
    .ctlLatch (ctlLatch),
    .strobe   (strobe)
  );

  ctlword_regs #(.WORD_W(WORD_W), .VOL_W(VOL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .serialMode (serialMode),
    .wordLen    (wordLen),
    .interpSel  (interpSel),
    .muteEn     (muteEn),
    .deempCurve (deempCurve),
    .softReset  (softReset),
    .volLeft    (volLeft),
    .volRight   (volRight)
  );

endmodule

// File: tb/ctlword_port_tb.sv
module ctlword_port_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctlClk = 1'b0;
  logic ctlData = 1'b0;
  logic ctlLatch = 1'b0;
  logic [1:0] serialMode, wordLen, interpSel, deempCurve;
  logic muteEn, softReset;
  logic [9:0] volLeft, volRight;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] mShift = '0;
  logic [9:0]  mCfg;
  logic [9:0]  mVolL, mVolR;

  always #4 clk = ~clk;

  ctlword_port u_dut (
    .clk(clk), .rst_n(rst_n), .ctlClk(ctlClk), .ctlData(ctlData), .ctlLatch(ctlLatch),
    .serialMode(serialMode), .wordLen(wordLen), .interpSel(interpSel), .muteEn(muteEn),
    .deempCurve(deempCurve), .softReset(softReset), .volLeft(volLeft), .volRight(volRight)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    cmp({tag, " serialMode"}, serialMode, mCfg[1:0]);
    cmp({tag, " wordLen"},    wordLen,    mCfg[3:2]);
    cmp({tag, " interpSel"},  interpSel,  mCfg[5:4]);
    cmp({tag, " muteEn"},     muteEn,     mCfg[6]);
    cmp({tag, " deempCurve"}, deempCurve, mCfg[8:7]);
    cmp({tag, " softReset"},  softReset,  mCfg[9]);
    cmp({tag, " volLeft"},    volLeft,    mVolL);
    cmp({tag, " volRight"},   volRight,   mVolR);
  endtask

  task automatic sendBit(input logic b);
    ctlClk = 1'b0; ctlData = b; waitCyc(4);
    ctlClk = 1'b1; waitCyc(4);
    mShift = {mShift[14:0], b};
  endtask

  // sends the low n bits of w, MSB first
  task automatic sendBits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic modelCommit();
    case (mShift[15:14])
      2'd0: mCfg  = mShift[9:0];
      2'd1: mVolL = mShift[9:0];
      2'd2: mVolR = mShift[9:0];
      default: ;
    endcase
  endtask

  task automatic latch();
    ctlLatch = 1'b1; waitCyc(4);
    ctlLatch = 1'b0; waitCyc(6);
    modelCommit();
  endtask

  task automatic writeWord(input logic [15:0] w, input string tag);
    sendBits(w, 16);
    // R4: nothing moves before the latch
    checkAll({tag, " R4 pre-latch"});
    latch();
    checkAll(tag);
  endtask

  initial begin
    mCfg = 10'b00_0000_1100; mVolL = '1; mVolR = '1;
    waitCyc(3);
    // R1: outputs during reset
    checkAll("R1 in reset");
    rst_n = 1'b1;
    waitCyc(3);
    checkAll("R1 after reset");

    // R5: config payload sweep, upper payload bits also varied
    for (int i = 0; i < 96; i++) begin
      logic [13:0] pay;
      pay = 14'((i * 1237 + 5) ^ (i << 6));
      writeWord({2'd0, pay}, "R5 R2 config");
    end

    // R6: volume sweeps on both channels
    for (int i = 0; i < 24; i++) begin
      writeWord({2'd1, 4'(i), 10'((i * 83) ^ 10'h155)}, "R6 volLeft");
      writeWord({2'd2, 4'(~i), 10'((i * 151) + 3)}, "R6 volRight");
    end

    // R7: reserved address leaves everything
    for (int i = 0; i < 8; i++)
      writeWord({2'd3, 14'(i * 2011)}, "R7 reserved");

    // R3: falling edge with toggled data and a gated idle gap
    sendBits({2'd1, 4'h0, 10'h2A5}, 16);
    ctlData = 1'b0; waitCyc(4);
    ctlClk = 1'b0; ctlData = 1'b1; waitCyc(20);
    ctlData = 1'b0; waitCyc(20);
    latch();
    checkAll("R3 falling edge ignored");

    // R8: partial words build on the old shift contents
    sendBits({2'd2, 14'h0123}, 16);
    latch();
    checkAll("R8 setup");
    for (int n = 1; n < 16; n += 3) begin
      sendBits(16'h3C5A ^ 16'(n * 97), n);
      latch();
      checkAll("R8 partial word");
    end

    // R9: last bit and latch rise in the same driving step
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w;
      w = {2'd1, 4'h0, 10'(k * 300 + 1)};
      sendBits(w[15:1], 15);
      ctlClk = 1'b0; ctlData = w[0]; waitCyc(4);
      ctlClk = 1'b1; ctlLatch = 1'b1;
      mShift = {mShift[14:0], w[0]};
      waitCyc(4);
      ctlLatch = 1'b0; waitCyc(6);
      modelCommit();
      checkAll("R9 coincident shift and latch");
    end

    // R1: reset mid-run restores defaults
    writeWord({2'd0, 14'h3FFF}, "R5 all ones");
    rst_n = 1'b0; waitCyc(2);
    mCfg = 10'b00_0000_1100; mVolL = '1; mVolR = '1; mShift = '0;
    checkAll("R1 reset again");
    rst_n = 1'b1; waitCyc(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule